// File: doc/BRIEF.md
# Chained Receive/Transmit DMA Request Sequencer

This block holds the buffer registers of a peripheral DMA channel that runs a receive direction and a transmit direction side by side. Each direction keeps a current buffer, a pointer and a byte counter, and a queued second buffer that is chained in when the first one finishes. Software loads these registers through a simple register port. It then writes a control word that switches each direction on or off.

Whenever a control write leaves at least one direction switched on, the block presents one transfer request to the attached peripheral. The request carries both pointers, both lengths and a final-request flag, and the block holds it until the peripheral accepts or rejects it. When the request is accepted and a queued buffer exists, the block moves the queued buffer into the current slot and issues a second request, which is always final. The register port stalls while any request is outstanding.

Top module: `pdma_chan`

## Requirements
- R1: After reset every pointer, counter and enable bit reads as 0, `req_valid` is low and `reg_ready` is high.
- R2: Register offsets from the block base 0x100 are: rx pointer 0x100, rx count 0x104, tx pointer 0x108, tx count 0x10C, rx queued pointer 0x110, rx queued count 0x114, tx queued pointer 0x118, tx queued count 0x11C, control 0x120 and status 0x124. Writes go to the addressed register, and reads return its live value. Counters keep only their low 16 bits.
- R3: In a control word, bit 0 switches rx on and bit 1 switches it off. Bit 8 switches tx on and bit 9 switches it off. If a word sets both bits for one direction, the direction is switched off. The status offset returns rx enable in bit 0 and tx enable in bit 8.
- R4: A control write that leaves any direction enabled raises `req_valid` from the next clock edge. The request carries the current pointers, and the length of each disabled direction is forced to 0. A control write that leaves both directions disabled issues no request.
- R5: The first request has `req_last` set only when every enabled direction has a queued count of 0. Queued counts of disabled directions are not considered.
- R6: When the first request is accepted, the current count of each enabled direction becomes 0. The registers of a disabled direction are left unchanged.
- R7: When a request is rejected, no pointer or counter changes, no second request follows, and the block returns to idle.
- R8: When a non-final first request is accepted, each enabled direction moves its queued pointer and count into current and clears its queued count. A second request carrying these values with `req_last` set is raised on the next cycle.
- R9: After the response to a second request, the current count of each enabled direction is 0.
- R10: `reg_ready` is low while a request is outstanding. Writes presented while it is low have no effect.
- R11: Reads of the control offset and of unmapped offsets return 0. Writes to the status offset or to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| reg_ready | output | 1 | High when the port accepts writes |
| req_valid | output | 1 | Transfer request outstanding |
| req_tx_ptr | output | PTR_W | Transmit buffer pointer |
| req_tx_len | output | CNT_W | Transmit length, 0 if tx disabled |
| req_rx_ptr | output | PTR_W | Receive buffer pointer |
| req_rx_len | output | CNT_W | Receive length, 0 if rx disabled |
| req_last | output | 1 | Request is the final one of the sequence |
| rsp_valid | input | 1 | Peripheral response, sampled while `req_valid` |
| rsp_accept | input | 1 | 1 = accepted, 0 = rejected |

## Verification
A request is due one register stage after the clock edge that takes the control write. It is therefore visible on the falling edge that follows that edge. A chained second request appears one edge after the accepting response. Counter clears and buffer promotion land on the same edge that samples the response. Read data is combinational, so the bench drives the address on a falling edge and samples a moment later. The request monitor compares each request on a falling edge against the item a driver task queued for it, and it answers only after the item's programmed delay.

// File: rtl/pdma_pkg.sv
package pdma_pkg;
   localparam int REG_W = 32;

   // word index within the register window (address bits [5:2])
   // bit0 = counter, bit1 = transmit, bit2 = queued buffer
   localparam int IDX_CTL  = 8;
   localparam int IDX_STAT = 9;

   // control / status bit positions
   localparam int RX_ON  = 0;
   localparam int RX_OFF = 1;
   localparam int TX_ON  = 8;
   localparam int TX_OFF = 9;

   localparam int DIR_RX = 0;
   localparam int DIR_TX = 1;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_FIRST = 2'd1,
      SQ_FINAL = 2'd2
   } seq_state_e;
endpackage

// File: rtl/pdma_dir_regs.sv
module pdma_dir_regs #(
   parameter int PTR_W = 32,
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [31:0]      wdata,
   input  logic             wr_ptr,
   input  logic             wr_cnt,
   input  logic             wr_nptr,
   input  logic             wr_ncnt,
   input  logic             clr_cur,
   input  logic             promote,
   output logic [PTR_W-1:0] cur_ptr,
   output logic [CNT_W-1:0] cur_cnt,
   output logic [PTR_W-1:0] nxt_ptr,
   output logic [CNT_W-1:0] nxt_cnt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_ptr <= '0;
         cur_cnt <= '0;
         nxt_ptr <= '0;
         nxt_cnt <= '0;
      end else begin
         if (promote)      cur_ptr <= nxt_ptr;
         else if (wr_ptr)  cur_ptr <= wdata[PTR_W-1:0];

         if (promote)      cur_cnt <= nxt_cnt;
         else if (clr_cur) cur_cnt <= '0;
         else if (wr_cnt)  cur_cnt <= wdata[CNT_W-1:0];

         if (wr_nptr)      nxt_ptr <= wdata[PTR_W-1:0];

         if (promote)      nxt_cnt <= '0;
         else if (wr_ncnt) nxt_cnt <= wdata[CNT_W-1:0];
      end
   end
endmodule

// File: rtl/pdma_seq.sv
module pdma_seq
   import pdma_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ctl_wr,
   input  logic [1:0] on_req,
   input  logic [1:0] off_req,
   input  logic [1:0] nxt_zero,
   input  logic       rsp_valid,
   input  logic       rsp_accept,
   output logic [1:0] dir_en,
   output logic       busy,
   output logic       last,
   output logic [1:0] clr_cur,
   output logic [1:0] promote
);
   seq_state_e state;
   logic [1:0] en_next;
   logic       all_empty;

   assign en_next   = (dir_en | on_req) & ~off_req;
   assign all_empty = &(~dir_en | nxt_zero);
   assign busy      = (state != SQ_IDLE);
   assign last      = (state == SQ_FINAL) || all_empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= SQ_IDLE;
         dir_en <= '0;
      end else begin
         unique case (state)
            SQ_IDLE: if (ctl_wr) begin
               dir_en <= en_next;
               if (|en_next) state <= SQ_FIRST;
            end
            SQ_FIRST: if (rsp_valid)
               state <= (rsp_accept && !all_empty) ? SQ_FINAL : SQ_IDLE;
            SQ_FINAL: if (rsp_valid) state <= SQ_IDLE;
            default: state <= SQ_IDLE;
         endcase
      end
   end

   for (genvar d = 0; d < 2; d++) begin : g_dir
      assign clr_cur[d] = dir_en[d] && rsp_valid &&
                          (((state == SQ_FIRST) && rsp_accept) || (state == SQ_FINAL));
      assign promote[d] = dir_en[d] && rsp_valid && rsp_accept &&
                          (state == SQ_FIRST) && !all_empty;
   end
endmodule

// File: rtl/pdma_chan.sv
module pdma_chan
   import pdma_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int BASE   = 'h100,
   parameter int PTR_W  = 32,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              reg_ready,
   output logic              req_valid,
   output logic [PTR_W-1:0]  req_tx_ptr,
   output logic [CNT_W-1:0]  req_tx_len,
   output logic [PTR_W-1:0]  req_rx_ptr,
   output logic [CNT_W-1:0]  req_rx_len,
   output logic              req_last,
   input  logic              rsp_valid,
   input  logic              rsp_accept
);
   localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);

   initial begin
      assert (ADDR_W >= 7) else $error("ADDR_W too small for register window");
      assert (BASE % 64 == 0) else $error("BASE must be 64-byte aligned");
      assert (PTR_W >= 1 && PTR_W <= REG_W) else $error("PTR_W out of range");
      assert (CNT_W >= 1 && CNT_W <= REG_W) else $error("CNT_W out of range");
   end

   logic       hit, wr_go, ctl_wr, busy, last;
   logic [3:0] idx;
   logic [1:0] dir_en, nxt_zero, clr_cur, promote;
   logic [1:0][PTR_W-1:0] cur_ptr, nxt_ptr;
   logic [1:0][CNT_W-1:0] cur_cnt, nxt_cnt;

   assign idx    = reg_addr[5:2];
   assign hit    = (reg_addr[ADDR_W-1:6] == BASE_A[ADDR_W-1:6]) && (reg_addr[1:0] == 2'b00);
   assign wr_go  = reg_wr && reg_ready && hit;
   assign ctl_wr = wr_go && (idx == 4'(IDX_CTL));

   for (genvar d = 0; d < 2; d++) begin : g_dir
      localparam logic [3:0] I_PTR  = 4'(d * 2);
      localparam logic [3:0] I_CNT  = 4'(d * 2 + 1);
      localparam logic [3:0] I_NPTR = 4'(d * 2 + 4);
      localparam logic [3:0] I_NCNT = 4'(d * 2 + 5);

      pdma_dir_regs #(.PTR_W(PTR_W), .CNT_W(CNT_W)) u_regs (
         .clk     (clk),
         .rst_n   (rst_n),
         .wdata   (reg_wdata),
         .wr_ptr  (wr_go && idx == I_PTR),
         .wr_cnt  (wr_go && idx == I_CNT),
         .wr_nptr (wr_go && idx == I_NPTR),
         .wr_ncnt (wr_go && idx == I_NCNT),
         .clr_cur (clr_cur[d]),
         .promote (promote[d]),
         .cur_ptr (cur_ptr[d]),
         .cur_cnt (cur_cnt[d]),
         .nxt_ptr (nxt_ptr[d]),
         .nxt_cnt (nxt_cnt[d])
      );
      assign nxt_zero[d] = (nxt_cnt[d] == '0);
   end

   pdma_seq u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctl_wr     (ctl_wr),
      .on_req     ({reg_wdata[TX_ON],  reg_wdata[RX_ON]}),
      .off_req    ({reg_wdata[TX_OFF], reg_wdata[RX_OFF]}),
      .nxt_zero   (nxt_zero),
      .rsp_valid  (rsp_valid),
      .rsp_accept (rsp_accept),
      .dir_en     (dir_en),
      .busy       (busy),
      .last       (last),
      .clr_cur    (clr_cur),
      .promote    (promote)
   );

   assign reg_ready  = !busy;
   assign req_valid  = busy;
   assign req_last   = last;
   assign req_tx_ptr = cur_ptr[DIR_TX];
   assign req_rx_ptr = cur_ptr[DIR_RX];
   assign req_tx_len = dir_en[DIR_TX] ? cur_cnt[DIR_TX] : '0;
   assign req_rx_len = dir_en[DIR_RX] ? cur_cnt[DIR_RX] : '0;

   always_comb begin
      reg_rdata = '0;
      if (hit) begin
         case (idx)
            4'd0, 4'd2: reg_rdata = REG_W'(cur_ptr[idx[1]]);
            4'd1, 4'd3: reg_rdata = REG_W'(cur_cnt[idx[1]]);
            4'd4, 4'd6: reg_rdata = REG_W'(nxt_ptr[idx[1]]);
            4'd5, 4'd7: reg_rdata = REG_W'(nxt_cnt[idx[1]]);
            4'(IDX_STAT): begin
               reg_rdata[RX_ON] = dir_en[DIR_RX];
               reg_rdata[TX_ON] = dir_en[DIR_TX];
            end
            default: reg_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/pdma_chan_chk.sv
module pdma_chan_chk #(
   parameter int ADDR_W = 12,
   parameter int BASE   = 'h100,
   parameter int PTR_W  = 32,
   parameter int CNT_W  = 16
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  reg_wr,
   input logic [ADDR_W-1:0]     reg_addr,
   input logic [31:0]           reg_wdata,
   input logic                  reg_ready,
   input logic                  req_valid,
   input logic                  req_last,
   input logic [PTR_W-1:0]      req_tx_ptr,
   input logic                  rsp_valid,
   input logic                  rsp_accept,
   input logic [1:0]            dir_en,
   input logic [1:0][CNT_W-1:0] cur_cnt
);
   localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(BASE + 'h20);

   p_busy_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> !reg_ready);

   p_issue_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_ready && reg_addr == CTL_A &&
       ((reg_wdata[0] && !reg_wdata[1]) || (reg_wdata[8] && !reg_wdata[9])))
      |=> req_valid);

   p_reject_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && rsp_valid && !rsp_accept) |=> !req_valid);

   p_chain_final_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && rsp_valid && rsp_accept && !req_last) |=> (req_valid && req_last));

   p_clear_tx_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && rsp_valid && rsp_accept && req_last && dir_en[1]) |=> (cur_cnt[1] == '0));

   p_clear_rx_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && rsp_valid && rsp_accept && req_last && dir_en[0]) |=> (cur_cnt[0] == '0));

   p_hold_ptr_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !rsp_valid) |=> $stable(req_tx_ptr));
endmodule

bind pdma_chan pdma_chan_chk #(
   .ADDR_W(ADDR_W), .BASE(BASE), .PTR_W(PTR_W), .CNT_W(CNT_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_wr     (reg_wr),
   .reg_addr   (reg_addr),
   .reg_wdata  (reg_wdata),
   .reg_ready  (reg_ready),
   .req_valid  (req_valid),
   .req_last   (req_last),
   .req_tx_ptr (req_tx_ptr),
   .rsp_valid  (rsp_valid),
   .rsp_accept (rsp_accept),
   .dir_en     (dir_en),
   .cur_cnt    (cur_cnt)
);

// File: tb/test_pdma_chan.sv
module test_pdma_chan;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        reg_ready, req_valid, req_last;
   logic [31:0] req_tx_ptr, req_rx_ptr;
   logic [15:0] req_tx_len, req_rx_len;
   logic        rsp_valid = 1'b0;
   logic        rsp_accept = 1'b0;

   int n_chk = 0;
   int n_bad = 0;

   typedef struct {
      logic [31:0] tp;
      logic [15:0] tl;
      logic [31:0] rp;
      logic [15:0] rl;
      logic        last;
      logic        acc;
      int          dly;
      string       tag;
   } req_t;
   req_t exp_q[$];

   always #2 clk = ~clk;   // 250 MHz

   pdma_chan i_pdma_chan (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_ready(reg_ready),
      .req_valid(req_valid), .req_tx_ptr(req_tx_ptr), .req_tx_len(req_tx_len),
      .req_rx_ptr(req_rx_ptr), .req_rx_len(req_rx_len), .req_last(req_last),
      .rsp_valid(rsp_valid), .rsp_accept(rsp_accept)
   );

   task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic expect_req(logic [31:0] tp, logic [15:0] tl, logic [31:0] rp,
                             logic [15:0] rl, logic last, logic acc, int dly, string tag);
      req_t it;
      it.tp = tp; it.tl = tl; it.rp = rp; it.rl = rl;
      it.last = last; it.acc = acc; it.dly = dly; it.tag = tag;
      exp_q.push_back(it);
   endtask

   task automatic wr(logic [11:0] a, logic [31:0] d);
      @(negedge clk);
      while (!reg_ready) @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(logic [11:0] a, logic [31:0] exp, string tag);
      @(negedge clk);
      reg_addr = a;
      #1;
      check(tag, 128'(reg_rdata), 128'(exp));
   endtask

   task automatic settle();
      repeat (16) @(negedge clk);
   endtask

   // monitor / responder
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && req_valid) begin
            if (exp_q.size() == 0) begin
               check("R4 unexpected request", 128'(req_valid), 128'(0));
               rsp_valid = 1'b1; rsp_accept = 1'b0;
            end else begin
               req_t it;
               it = exp_q.pop_front();
               check(it.tag, {req_tx_ptr, req_tx_len, req_rx_ptr, req_rx_len, req_last},
                     {it.tp, it.tl, it.rp, it.rl, it.last});
               repeat (it.dly) @(negedge clk);
               rsp_valid = 1'b1; rsp_accept = it.acc;
            end
            @(negedge clk);
            rsp_valid = 1'b0;
         end
      end
   end

   // watchdog
   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      for (int a = 'h100; a <= 'h124; a += 4) rd(12'(a), 32'h0, "R1 reset register");
      check("R1 ready after reset", 128'(reg_ready), 128'(1));
      check("R1 no request after reset", 128'(req_valid), 128'(0));

      // R2 write / readback, counter truncation
      wr(12'h104, 32'h0001_2345);
      rd(12'h104, 32'h0000_2345, "R2 rx count 16-bit");
      wr(12'h118, 32'hCAFE_0001);
      rd(12'h118, 32'hCAFE_0001, "R2 tx queued pointer");
      wr(12'h118, 32'h0);

      // R4 R5 R6 single direction
      wr(12'h108, 32'h2000_0000); wr(12'h10C, 32'd5);
      wr(12'h100, 32'h3000_0040); wr(12'h104, 32'd7);
      expect_req(32'h2000_0000, 16'd5, 32'h3000_0040, 16'd0, 1'b1, 1'b1, 0, "R4 tx-only request");
      wr(12'h120, 32'h100);
      settle();
      rd(12'h10C, 32'd0, "R6 tx count cleared");
      rd(12'h104, 32'd7, "R6 rx count untouched");
      rd(12'h124, 32'h100, "R3 status tx on");

      // R7 reject
      wr(12'h10C, 32'd9);
      expect_req(32'h2000_0000, 16'd9, 32'h3000_0040, 16'd0, 1'b1, 1'b0, 1, "R7 rejected request");
      wr(12'h120, 32'h0);
      settle();
      rd(12'h10C, 32'd9, "R7 count kept after reject");
      rd(12'h108, 32'h2000_0000, "R7 pointer kept after reject");
      check("R7 idle after reject", 128'(reg_ready), 128'(1));

      // R8 R9 chain both directions
      wr(12'h118, 32'h4000_0100); wr(12'h11C, 32'd4);
      wr(12'h110, 32'h5000_0200); wr(12'h114, 32'd2);
      expect_req(32'h2000_0000, 16'd9, 32'h3000_0040, 16'd7, 1'b0, 1'b1, 0, "R5 first not last");
      expect_req(32'h4000_0100, 16'd4, 32'h5000_0200, 16'd2, 1'b1, 1'b1, 0, "R8 chained final");
      wr(12'h120, 32'h001);
      settle();
      rd(12'h108, 32'h4000_0100, "R8 tx pointer promoted");
      rd(12'h100, 32'h5000_0200, "R8 rx pointer promoted");
      rd(12'h11C, 32'd0, "R8 tx queued count cleared");
      rd(12'h114, 32'd0, "R8 rx queued count cleared");
      rd(12'h10C, 32'd0, "R9 tx count cleared");
      rd(12'h104, 32'd0, "R9 rx count cleared");
      rd(12'h124, 32'h101, "R3 status both on");

      // R5 disabled direction's queued count ignored
      expect_req(32'h4000_0100, 16'd0, 32'h5000_0200, 16'd0, 1'b1, 1'b1, 0, "R4 rx-only after tx off");
      wr(12'h120, 32'h200);
      settle();
      wr(12'h104, 32'd3); wr(12'h11C, 32'd6);
      expect_req(32'h4000_0100, 16'd0, 32'h5000_0200, 16'd3, 1'b1, 1'b1, 0, "R5 last ignores tx queue");
      wr(12'h120, 32'h0);
      settle();
      rd(12'h11C, 32'd6, "R6 disabled tx queue untouched");
      rd(12'h124, 32'h001, "R3 status rx only");

      // R3 on+off in one word: off wins, no request
      wr(12'h120, 32'h003);
      settle();
      rd(12'h124, 32'h0, "R3 disable wins");

      // R10 stall while outstanding
      wr(12'h10C, 32'd1);
      expect_req(32'h4000_0100, 16'd1, 32'h5000_0200, 16'd0, 1'b0, 1'b1, 4, "R10 delayed first");
      expect_req(32'h4000_0100, 16'd6, 32'h5000_0200, 16'd0, 1'b1, 1'b1, 0, "R8 chained tx only");
      wr(12'h120, 32'h100);
      @(negedge clk);
      check("R10 ready low while busy", 128'(reg_ready), 128'(0));
      reg_wr = 1'b1; reg_addr = 12'h108; reg_wdata = 32'hDEAD_0000;
      @(negedge clk);
      reg_wr = 1'b0;
      settle();
      rd(12'h108, 32'h4000_0100, "R10 write while busy ignored");

      // R11 unmapped / control / status write
      rd(12'h128, 32'h0, "R11 unmapped read");
      rd(12'h000, 32'h0, "R11 outside window read");
      rd(12'h120, 32'h0, "R11 control reads zero");
      wr(12'h124, 32'hFFFF_FFFF);
      rd(12'h124, 32'h100, "R11 status write ignored");

      settle();
      check("R4 all expected requests seen", 128'(exp_q.size()), 128'(0));
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule